// File: doc/BRIEF.md
# Stretched-Strobe Peripheral Bridge

The bridge connects a single request port to a slow peripheral bus. Each request carries an initiator code: processor, DMA or external port. The bridge decodes the request address into one of two strobe regions, and each region has a public half and a private half. It then checks whether that initiator may reach that half. A granted access drives one active-low strobe. The strobe has an idle-high phase followed by an active-low phase, and each phase lasts n cycles, where n is a factor programmed separately for each strobe. A denied or unmapped access never reaches the bus and returns an error at once.

A small configuration port sets up the bridge. It holds the two stretch factors, the permission bits for the DMA and external initiators, and a write-posting enable. When posting is enabled, a processor write is acknowledged as soon as it is captured. The bridge then finishes the bus cycle in the background and holds off any new request until the buffer is empty again.

Top module: `periph_bridge`

## Requirements
- R1: Address decode uses bit AW-1 and bit AW-2 of the request address. If bit AW-1 is 1, the address is unmapped. Otherwise bit AW-2 selects the strobe: 0 selects pb_stb_n[0] and 1 selects pb_stb_n[1]. Bit AW-3 set to 1 marks the private half of the region.
- R2: Both strobes are active low. At most one strobe is low at any time, and no strobe is low while req_ready is high.
- R3: With an effective factor n, a granted access keeps its strobe high for the n cycles after acceptance and then low for n cycles. rsp_done rises in cycle 2n+1 after the accepting edge. A factor of 0 counts as 1. The factor is taken from the selected strobe's register when the request is accepted.
- R4: Initiator code 0 (processor) is granted both the public half and the private half of every mapped region.
- R5: Initiator code 1 (DMA) is always granted the public half. It is granted the private half only when permission bit 0 is set.
- R6: Initiator code 2 (external port) needs permission bit 1 for the public half and permission bit 2 for the private half. Initiator code 3 is always denied.
- R7: A denied or unmapped access drives no strobe. It returns rsp_done together with rsp_err in the cycle after acceptance.
- R8: A granted read returns the pb_rdata value from the last low cycle of its strobe. That value appears on rsp_rdata during the single-cycle rsp_done pulse, with rsp_err low.
- R9: When permission bit 3 is set, a processor write is posted. rsp_done (with rsp_err low) arrives in the cycle after acceptance, the strobe still runs its full length, and no second rsp_done is given. Writes from DMA or external initiators are never posted.
- R10: cfg_addr 0 writes the strobe-0 factor and cfg_addr 1 writes the strobe-1 factor. cfg_addr 2 writes the permission bits in cfg_wdata[3:0]: bit0 DMA private, bit1 external public, bit2 external private, bit3 posting enable. All of these reset to 0.
- R11: pb_addr, pb_write and pb_wdata hold the accepted request's values and stay stable for the whole access.
- R12: req_ready is low from acceptance of a granted access until its strobe ends, whether or not the write was posted. A request presented during that time is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | FW | Configuration write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_init | input | 2 | Initiator code (0 processor, 1 DMA, 2 external) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion is an error |
| rsp_rdata | output | DW | Read data |
| pb_stb_n | output | 2 | Active-low peripheral strobes |
| pb_addr | output | AW | Peripheral address |
| pb_write | output | 1 | Peripheral write direction |
| pb_wdata | output | DW | Peripheral write data |
| pb_rdata | input | DW | Peripheral read data |

## Verification
The hardest case to reach is a request arriving while a posted write is still running on the bus. At that point the requester has already received its completion, but the strobe has not yet started. To create it, the bench acknowledges a posted write and raises a read request in the very next cycle. It then counts how many cycles the read stays stalled against the write's strobe length. The bench also drives a peripheral data value that changes every cycle, so that a sample taken one cycle early or late returns the wrong word.

// File: rtl/periph_bridge.sv
module periph_bridge #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [FW-1:0] cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_init,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic [1:0]    pb_stb_n,
  output logic [AW-1:0] pb_addr,
  output logic          pb_write,
  output logic [DW-1:0] pb_wdata,
  input  logic [DW-1:0] pb_rdata
);
  localparam int CW = FW + 1;

  logic [FW-1:0] fac0, fac1, half;
  logic [3:0]    perm;
  logic [CW-1:0] cnt;
  logic          busy, posted, sel;
  logic          allow, grant, acc, post_in, stb_act, last;
  logic [FW-1:0] fac_in, n_in;

  wire mapped  = ~req_addr[AW-1];
  wire sel_in  = req_addr[AW-2];
  wire priv_in = req_addr[AW-3];

  always_comb begin
    case (req_init)
      2'd0:    allow = 1'b1;
      2'd1:    allow = ~priv_in | perm[0];
      2'd2:    allow = priv_in ? perm[2] : perm[1];
      default: allow = 1'b0;
    endcase
  end

  assign grant   = mapped & allow;
  assign req_ready = ~busy;
  assign acc     = req_valid & req_ready;
  assign post_in = perm[3] & req_write & (req_init == 2'd0);
  assign fac_in  = sel_in ? fac1 : fac0;
  assign n_in    = (fac_in == '0) ? FW'(1) : fac_in;
  assign stb_act = busy && (cnt >= {1'b0, half});
  assign last    = busy && (cnt == ({half, 1'b0} - CW'(1)));
  assign pb_stb_n = ~({sel, ~sel} & {2{stb_act}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fac0 <= '0; fac1 <= '0; perm <= '0;
      busy <= 1'b0; posted <= 1'b0; sel <= 1'b0;
      cnt <= '0; half <= '0;
      pb_addr <= '0; pb_write <= 1'b0; pb_wdata <= '0;
      rsp_done <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          2'd0:    fac0 <= cfg_wdata;
          2'd1:    fac1 <= cfg_wdata;
          2'd2:    perm <= cfg_wdata[3:0];
          default: ;
        endcase
      end
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      if (acc) begin
        if (!grant) begin
          rsp_done <= 1'b1;
          rsp_err  <= 1'b1;
        end else begin
          busy     <= 1'b1;
          cnt      <= '0;
          half     <= n_in;
          sel      <= sel_in;
          posted   <= post_in;
          pb_addr  <= req_addr;
          pb_write <= req_write;
          pb_wdata <= req_wdata;
          if (post_in) rsp_done <= 1'b1;
        end
      end else if (busy) begin
        cnt <= cnt + CW'(1);
        if (last) begin
          busy <= 1'b0;
          if (!posted) rsp_done <= 1'b1;
          if (!pb_write) rsp_rdata <= pb_rdata;
        end
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~pb_stb_n) <= 1);                                           // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> &pb_stb_n);                                              // R2
  AST_DENY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !grant) |=> (rsp_done && rsp_err && &pb_stb_n));               // R7
  AST_DMA_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_init == 2'd1 && priv_in && !perm[0]) |=> rsp_err);         // R5
  AST_PROC_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_init == 2'd0 && mapped) |=> !rsp_err);                     // R4
  AST_HOLD_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |->
      ($stable(pb_addr) && $stable(pb_write) && $stable(pb_wdata)));       // R11
  AST_STB_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(&pb_stb_n) |-> !rsp_err);                                            // R7
endmodule

// File: tb/test_periph_bridge.sv
module test_periph_bridge;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_addr = 0;
  logic [3:0]  cfg_wdata = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [1:0]  req_init = 0;
  logic        req_write = 0;
  logic [11:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic        rsp_done, rsp_err;
  logic [15:0] rsp_rdata;
  logic [1:0]  pb_stb_n;
  logic [11:0] pb_addr;
  logic        pb_write;
  logic [15:0] pb_wdata;
  logic [15:0] pb_rdata = 16'h0100;

  int n_vec = 0, n_bad = 0;
  bit summary_done = 0;

  int r_done, r_idle, r_ndone, r_high, r_low0, r_low1, r_bus_bad;
  bit r_err;
  logic [15:0] r_rdata, r_last;

  always #2.5 clk = ~clk;
  always @(posedge clk) pb_rdata <= pb_rdata + 16'h1357;

  periph_bridge i_periph_bridge (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_init(req_init), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .pb_stb_n(pb_stb_n), .pb_addr(pb_addr), .pb_write(pb_write),
    .pb_wdata(pb_wdata), .pb_rdata(pb_rdata));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic cfg(input [1:0] a, input [3:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic launch(input [1:0] ini, input bit wr, input [11:0] ad, input [15:0] wd);
    req_init = ini; req_write = wr; req_addr = ad; req_wdata = wd; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic watch();
    int k;
    bit seen_low;
    k = 1; seen_low = 0;
    r_done = 0; r_ndone = 0; r_high = 0; r_low0 = 0; r_low1 = 0; r_bus_bad = 0; r_err = 0;
    r_last = 16'hxxxx;
    for (int i = 0; i < 200; i++) begin
      if (rsp_done) begin
        r_ndone++;
        if (r_done == 0) begin r_done = k; r_err = rsp_err; r_rdata = rsp_rdata; end
      end
      if (!pb_stb_n[0]) r_low0++;
      if (!pb_stb_n[1]) r_low1++;
      if (&pb_stb_n && !req_ready && !seen_low) r_high++;
      if (!(&pb_stb_n)) begin
        seen_low = 1;
        r_last = pb_rdata;
        if (pb_addr != req_addr || pb_write != req_write || (req_write && pb_wdata != req_wdata))
          r_bus_bad++;
      end
      if (req_ready && r_done != 0) break;
      @(negedge clk); k++;
    end
    r_idle = k;
  endtask

  task automatic access(input [1:0] ini, input bit wr, input [11:0] ad, input [15:0] wd);
    @(negedge clk);
    launch(ini, wr, ad, wd);
    watch();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1, "R2 reset ready", req_ready, 1);
    chk(pb_stb_n == 2'b11, "R2 reset strobes", pb_stb_n, 3);
    chk(rsp_done == 0, "R10 reset done", rsp_done, 0);
  endtask

  task automatic t_min_factor();
    access(2'd0, 0, 12'h010, 0);
    chk(r_done == 3, "R3 done cycle n=0->1", r_done, 3);
    chk(r_low0 == 1 && r_low1 == 0, "R1 strobe0 low count", r_low0, 1);
    chk(r_high == 1, "R3 high phase n=1", r_high, 1);
    chk(!r_err, "R4 proc public grant", r_err, 0);
    chk(r_rdata == r_last, "R8 read sample", r_rdata, r_last);
    chk(r_ndone == 1, "R8 single done", r_ndone, 1);
  endtask

  task automatic t_strobe1_private();
    cfg(2'd1, 4'd3);
    access(2'd0, 0, 12'h640, 0);
    chk(r_done == 7, "R3 done cycle n=3", r_done, 7);
    chk(r_low1 == 3 && r_low0 == 0, "R1 strobe1 low count", r_low1, 3);
    chk(r_high == 3, "R3 high phase n=3", r_high, 3);
    chk(!r_err, "R4 proc private grant", r_err, 0);
    chk(r_rdata == r_last, "R8 read sample n=3", r_rdata, r_last);
  endtask

  task automatic t_write_hold();
    cfg(2'd0, 4'd5);
    access(2'd0, 1, 12'h234, 16'hBEEF);
    chk(r_done == 11, "R12 nonposted done n=5", r_done, 11);
    chk(r_low0 == 5, "R3 low phase n=5", r_low0, 5);
    chk(r_bus_bad == 0, "R11 bus stable", r_bus_bad, 0);
    chk(r_idle == 11, "R12 ready returns", r_idle, 11);
  endtask

  task automatic t_dma();
    cfg(2'd0, 4'd1);
    access(2'd1, 0, 12'h200, 0);
    chk(r_done == 1 && r_err, "R5 dma private denied", r_err, 1);
    chk(r_low0 + r_low1 == 0, "R7 no strobe on deny", r_low0 + r_low1, 0);
    access(2'd1, 0, 12'h000, 0);
    chk(!r_err && r_done == 3, "R5 dma public granted", r_done, 3);
    cfg(2'd2, 4'b0001);
    access(2'd1, 1, 12'h200, 16'h1111);
    chk(!r_err && r_low0 == 1, "R5 dma private with bit0", r_low0, 1);
  endtask

  task automatic t_ext();
    cfg(2'd2, 4'b0000);
    access(2'd2, 0, 12'h400, 0);
    chk(r_err && r_done == 1, "R6 ext public denied", r_err, 1);
    cfg(2'd2, 4'b0010);
    access(2'd2, 0, 12'h400, 0);
    chk(!r_err && r_low1 == 3, "R6 ext public with bit1", r_low1, 3);
    access(2'd2, 0, 12'h600, 0);
    chk(r_err, "R6 ext private needs bit2", r_err, 1);
    cfg(2'd2, 4'b0100);
    access(2'd2, 0, 12'h600, 0);
    chk(!r_err && r_low1 == 3, "R6 ext private with bit2", r_low1, 3);
    access(2'd3, 0, 12'h000, 0);
    chk(r_err && r_low0 + r_low1 == 0, "R6 code3 denied", r_err, 1);
  endtask

  task automatic t_unmapped();
    access(2'd0, 1, 12'h800, 16'h5555);
    chk(r_err && r_done == 1, "R7 unmapped error", r_done, 1);
    chk(r_low0 + r_low1 == 0, "R1 unmapped no strobe", r_low0 + r_low1, 0);
    chk(r_ndone == 1, "R7 single response", r_ndone, 1);
  endtask

  task automatic t_posted();
    int stall, lows;
    cfg(2'd0, 4'd2);
    cfg(2'd2, 4'b1000);
    @(negedge clk);
    launch(2'd0, 1, 12'h044, 16'hA5A5);
    chk(rsp_done && !rsp_err, "R9 posted early done", rsp_done, 1);
    chk(!req_ready, "R12 busy after post", req_ready, 0);
    req_init = 0; req_write = 0; req_addr = 12'h050; req_valid = 1;
    stall = 0; lows = 0;
    for (int i = 0; i < 50 && !req_ready; i++) begin
      if (!pb_stb_n[0]) lows++;
      if (pb_wdata != 16'hA5A5 || pb_addr != 12'h044) chk(0, "R11 posted bus hold", pb_wdata, 16'hA5A5);
      if (rsp_done && i > 0) chk(0, "R9 no second done", 1, 0);
      stall++;
      @(negedge clk);
    end
    chk(stall == 4, "R12 stall length", stall, 4);
    chk(lows == 2, "R9 posted strobe length", lows, 2);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    watch();
    chk(!r_err && r_done == 5 && r_rdata == r_last, "R8 read after posted", r_done, 5);
    access(2'd1, 1, 12'h044, 16'h7777);
    chk(r_done == 5 && r_ndone == 1, "R9 dma write not posted", r_done, 5);
  endtask

  task automatic t_latch();
    cfg(2'd0, 4'd4);
    @(negedge clk);
    launch(2'd0, 0, 12'h020, 0);
    cfg_we = 1; cfg_addr = 2'd0; cfg_wdata = 4'd1;
    @(negedge clk);
    cfg_we = 0;
    watch();
    chk(r_done == 8, "R3 factor latched", r_done + 1, 9);
    chk(r_low0 == 4, "R3 latched low phase", r_low0 + 0, 4);
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_min_factor();
    t_strobe1_private();
    t_write_hold();
    t_dma();
    t_ext();
    t_unmapped();
    t_posted();
    t_latch();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule